// File: doc/BRIEF.md
# RTC Interrupt Control Register

This block is the interrupt control register of a real-time clock, together with the logic that drives the clock's interrupt pin. The register holds two sticky event flags, one for alarm matches and one for timer expiries. It also holds an enable for each flag and a mode bit that chooses how timer events reach the pin. An alarm comparator elsewhere sends a one-cycle pulse on each match, and a countdown timer elsewhere sends a one-cycle pulse on each expiry.

Software writes the register through a simple write port and reads it back on a parallel bus. A flag is cleared by writing 0 to its bit. Writing 1 to a flag bit leaves the flag as it is, so software can change the enables without losing a pending event. The pin is active low.

In single-shot timer mode, the timer's effect on the pin follows its flag. In repeated mode, the pin instead pulses once for each expiry.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, every readback bit is 0 and `irq_n` is 1.
- R2: The readback layout is: bit 4 is timer mode (1 = repeated, 0 = single-shot), bit 3 is the alarm flag, bit 2 is the timer flag, bit 1 is the alarm enable, and bit 0 is the timer enable. Bits 7:5 always read 0. Mode and enables read back the last value written to them.
- R3: The cycle after a pulse on `alarm_hit`, the alarm flag reads 1. It then stays 1 until a write clears it.
- R4: The cycle after a pulse on `timer_hit`, the timer flag reads 1. It then stays 1 until a write clears it.
- R5: A write with 0 in a flag bit clears that flag. A write with 1 in a flag bit leaves the flag unchanged. If an event pulse arrives in the same cycle as a clearing write, the event wins and the flag is set.
- R6: `irq_n` is 0 whenever the alarm flag and the alarm enable are both 1.
- R7: In single-shot mode, the timer drives `irq_n` low for as long as the timer flag and the timer enable are both 1.
- R8: In repeated mode with the timer enable set, `irq_n` goes low for exactly the one cycle after each `timer_hit` pulse, whatever the state of the timer flag.
- R9: A flag whose enable is 0 does not pull `irq_n` low. With both enables 0, `irq_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data for bits 4:0 |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| timer_hit | input | 1 | One-cycle timer expiry pulse |
| rd_data | output | 8 | Register readback |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions check on every cycle that:
- each event pulse sets its flag on the next cycle;
- a flag holds when there is neither a write nor an event;
- the upper bits read 0;
- an enabled alarm flag or, in single-shot mode, an enabled timer flag holds the pin low;
- a repeated-mode expiry pulls the pin low on the next cycle;
- the pin stays high when both enables are off.

Only the bench scenarios can show the following:
- the pin returns high one cycle after a repeated-mode expiry, while the timer flag is still set;
- writing 1 to a flag leaves it set;
- an event beats a clearing write in the same cycle;
- enabling an already pending flag asserts the pin at once.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  input  logic       alarm_hit,
  input  logic       timer_hit,
  output logic [7:0] rd_data,
  output logic       irq_n
);

  logic rpt_mode, alm_flag, tmr_flag, alm_en, tmr_en, tmr_pulse;

  logic alm_flag_d, tmr_flag_d;
  assign alm_flag_d = alarm_hit | (alm_flag & ~(wr_en & ~wr_data[3]));
  assign tmr_flag_d = timer_hit | (tmr_flag & ~(wr_en & ~wr_data[2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_mode  <= 1'b0;
      alm_flag  <= 1'b0;
      tmr_flag  <= 1'b0;
      alm_en    <= 1'b0;
      tmr_en    <= 1'b0;
      tmr_pulse <= 1'b0;
    end else begin
      alm_flag  <= alm_flag_d;
      tmr_flag  <= tmr_flag_d;
      tmr_pulse <= timer_hit;
      if (wr_en) begin
        rpt_mode <= wr_data[4];
        alm_en   <= wr_data[1];
        tmr_en   <= wr_data[0];
      end
    end
  end

  logic tmr_src;
  assign tmr_src = rpt_mode ? tmr_pulse : tmr_flag;

  assign irq_n   = ~((alm_flag & alm_en) | (tmr_src & tmr_en));
  assign rd_data = {3'b000, rpt_mode, alm_flag, tmr_flag, alm_en, tmr_en};

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       alarm_hit,
  input logic       timer_hit,
  input logic [7:0] rd_data,
  input logic       irq_n
);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  p_alarm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> rd_data[3]);

  p_timer_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_hit |=> rd_data[2]);

  p_alarm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_hit && !wr_en && rd_data[3]) |=> rd_data[3]);

  p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_hit && !wr_en && rd_data[2]) |=> rd_data[2]);

  p_alarm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && rd_data[1]) |-> !irq_n);

  p_single_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[4] && rd_data[2] && rd_data[0]) |-> !irq_n);

  p_repeat_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && rd_data[0] && timer_hit && !wr_en) |=> !irq_n);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[1] && !rd_data[0]) |-> irq_n);

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .alarm_hit(alarm_hit),
  .timer_hit(timer_hit), .rd_data(rd_data), .irq_n(irq_n)
);

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = 5'd0;
  logic       alarm_hit = 1'b0;
  logic       timer_hit = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .alarm_hit(alarm_hit), .timer_hit(timer_hit),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {irq_n,rd}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_state(string req, logic [7:0] rd, logic irq);
    check(req, {irq_n, rd_data}, {irq, rd});
  endtask

  task automatic step(logic we, logic [4:0] d, logic a, logic t);
    @(negedge clk);
    wr_en = we; wr_data = d; alarm_hit = a; timer_hit = t;
    @(negedge clk);
    wr_en = 1'b0; alarm_hit = 1'b0; timer_hit = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_state("R1", 8'h00, 1'b1);
  endtask

  task automatic t_readback();
    step(1, 5'h1F, 0, 0);
    expect_state("R2", 8'h13, 1'b1);
    step(1, 5'h00, 0, 0);
    expect_state("R2", 8'h00, 1'b1);
  endtask

  task automatic t_alarm();
    step(0, 5'h00, 1, 0);
    expect_state("R3 R9", 8'h08, 1'b1);
    step(1, 5'h0A, 0, 0);
    expect_state("R6", 8'h0A, 1'b0);
    idle(); idle();
    expect_state("R3", 8'h0A, 1'b0);
    step(1, 5'h02, 0, 0);
    expect_state("R5", 8'h02, 1'b1);
  endtask

  task automatic t_single();
    step(1, 5'h01, 0, 0);
    step(0, 5'h00, 0, 1);
    expect_state("R4 R7", 8'h05, 1'b0);
    idle(); idle(); idle();
    expect_state("R7", 8'h05, 1'b0);
    step(1, 5'h01, 0, 0);
    expect_state("R5", 8'h01, 1'b1);
  endtask

  task automatic t_repeat();
    step(1, 5'h11, 0, 0);
    step(0, 5'h00, 0, 1);
    expect_state("R8", 8'h15, 1'b0);
    idle();
    expect_state("R8", 8'h15, 1'b1);
    step(0, 5'h00, 0, 1);
    expect_state("R8", 8'h15, 1'b0);
    idle();
    expect_state("R8", 8'h15, 1'b1);
  endtask

  task automatic t_keep_and_race();
    step(0, 5'h00, 1, 1);
    step(1, 5'h0C, 0, 0);
    expect_state("R5", 8'h0C, 1'b1);
    step(1, 5'h00, 1, 0);
    expect_state("R5", 8'h08, 1'b1);
    step(1, 5'h00, 0, 1);
    expect_state("R5", 8'h04, 1'b1);
    step(1, 5'h00, 0, 0);
    expect_state("R9", 8'h00, 1'b1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_readback();
    t_alarm();
    t_single();
    t_repeat();
    t_keep_and_race();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule